// File: doc/BRIEF.md
# Host-to-Serial Byte Staging Buffer

This block stages bytes between a 16-bit host data register and a byte-wide serial bus engine. In the transmit direction the host deposits a whole 16-bit word (two bytes) per access. The last access of a transfer may instead carry a single byte. The engine then pulls the bytes one at a time, oldest first. In the receive direction the engine hands in bytes one at a time, and the host collects them two per read.

A byte-order select decides which half of the host word travels first. It applies to writes and reads alike, so both directions present the same word layout to software. The block raises event flags for the status unit: transmit underflow, transmit ready, receive overrun, receive ready, and a flag for a read that found only a lone byte. A start strobe, issued with each new start condition, empties both directions at once.

Top module: `bbuf_top`

## Requirements
- R1: After reset both fill levels are 0, every flag output is 0 and `tx_data_o` is 0.
- R2: An accepted 16-bit write queues two bytes behind any already queued. With `swap_i`=0, `host_wdata_i[7:0]` goes out first and `[15:8]` second. With `swap_i`=1 the order is reversed. Each pop takes the oldest queued byte.
- R3: An accepted 8-bit write (`host_wr_byte_i`=1) queues `host_wdata_i[7:0]` as one byte behind those already queued, whatever the value of `swap_i`.
- R4: A host write, 8- or 16-bit, is ignored when more than DEPTH-2 bytes (2 by default) are queued before it. In that case level, queued bytes and flags do not change.
- R5: `tx_data_o` shows the oldest queued byte, or 0 when the queue is empty. A pop on an empty queue sets `tx_udf_o`. Every pop sets `tx_rdy_o`, unless a same-cycle write clears it as in R6.
- R6: An accepted write clears `tx_udf_o`. It also clears `tx_rdy_o` when more than DEPTH-2 bytes are queued after it.
- R7: Received bytes fill lanes 0 upward in arrival order. A push while DEPTH bytes are held drops the byte and sets `rx_ovr_o`. Every push sets `rx_rdy_o`.
- R8: `host_rdata_o` shows lanes 0 and 1. With `swap_i`=0 lane 0 is in bits [7:0]. With `swap_i`=1 lane 0 is in bits [15:8].
- R9: A read with one byte held sets `single_o` and empties the receive side. A read with two or more held lowers the level by 2, and when more than two were held the rest shift down by two lanes.
- R10: A read clears `rx_ovr_o`. It clears `rx_rdy_o` when the receive level after the read is 0.
- R11: `start_i` empties both directions and clears `single_o`, overriding any host or bus operation in the same cycle.
- R12: A write and a pop in one cycle act as if the pop came first; write acceptance is judged on the level before the pop. A read and a push in one cycle act as if the read came first; overflow is judged on the level after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New start condition: empty the buffer |
| swap_i | input | 1 | Byte order select for host words |
| host_wr_i | input | 1 | Host data write strobe |
| host_wr_byte_i | input | 1 | Write carries one byte instead of two |
| host_wdata_i | input | 2*BYTE_W | Host write word |
| host_rd_i | input | 1 | Host data read strobe |
| host_rdata_o | output | 2*BYTE_W | Host read word |
| tx_pop_i | input | 1 | Engine takes one transmit byte |
| tx_data_o | output | BYTE_W | Oldest transmit byte, 0 when empty |
| rx_push_i | input | 1 | Engine delivers one receive byte |
| rx_data_i | input | BYTE_W | Received byte |
| tx_level_o | output | $clog2(DEPTH+1) | Queued transmit bytes |
| rx_level_o | output | $clog2(DEPTH+1) | Held receive bytes |
| tx_udf_o | output | 1 | Transmit underflow flag |
| tx_rdy_o | output | 1 | Transmit ready flag |
| rx_ovr_o | output | 1 | Receive overrun flag |
| rx_rdy_o | output | 1 | Receive ready flag |
| single_o | output | 1 | Lone-byte read flag |

## Verification
The host and the engine can act on the same side in the same cycle. A host write can meet an engine pop, and a host read can meet an engine push. The bench provokes both by raising the two strobes together. It does this with the queue part full, and also at the acceptance and overflow boundaries. The scoreboard records the expected byte or word in the order that R12 defines, so a pop that took the freshly written byte, or a push that landed in a lane the read was about to discard, shows up as a mismatch. The fill levels after each collision are then compared with the net count.

// File: rtl/bbuf_pkg.sv
package bbuf_pkg;

  typedef struct packed {
    logic single;
    logic rx_ovr;
    logic rx_rdy;
    logic tx_udf;
    logic tx_rdy;
  } bbuf_flags_t;

endpackage

// File: rtl/bbuf_order.sv
module bbuf_order #(
  parameter int BW = 8
) (
  input  logic          swap_i,
  input  logic [2*BW-1:0] wword_i,
  output logic [BW-1:0] first_o,
  output logic [BW-1:0] second_o,
  input  logic [BW-1:0] lane0_i,
  input  logic [BW-1:0] lane1_i,
  output logic [2*BW-1:0] rword_o
);

  always_comb begin
    if (swap_i) begin
      first_o  = wword_i[2*BW-1:BW];
      second_o = wword_i[BW-1:0];
      rword_o  = {lane0_i, lane1_i};
    end else begin
      first_o  = wword_i[BW-1:0];
      second_o = wword_i[2*BW-1:BW];
      rword_o  = {lane1_i, lane0_i};
    end
  end

endmodule

// File: rtl/bbuf_tx_queue.sv
module bbuf_tx_queue #(
  parameter  int DEPTH = 4,
  parameter  int BW    = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          wr_byte_i,
  input  logic [BW-1:0] first_i,
  input  logic [BW-1:0] second_i,
  input  logic [BW-1:0] byte_i,
  input  logic          pop_i,
  output logic [BW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] level_nxt_o,
  output logic          wr_acc_o,
  output logic          pop_empty_o
);

  logic [DEPTH-1:0][BW-1:0] q_q, q_n;
  logic [LW-1:0]            level_q, level_n;
  logic                     pop_hit;

  // oldest byte sits at index level-1; writes shift older bytes upward
  always_comb begin
    wr_acc_o    = wr_i & (level_q <= LW'(DEPTH - 2));
    pop_hit     = pop_i & (level_q != '0);
    pop_empty_o = pop_i & (level_q == '0);
    data_o      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == LW'(i + 1)) data_o = q_q[i];
    end
    q_n     = q_q;
    level_n = level_q;
    if (pop_hit) level_n = level_n - LW'(1);
    if (wr_acc_o) begin
      if (wr_byte_i) begin
        for (int i = 1; i < DEPTH; i++) q_n[i] = q_q[i-1];
        q_n[0]  = byte_i;
        level_n = level_n + LW'(1);
      end else begin
        for (int i = 2; i < DEPTH; i++) q_n[i] = q_q[i-2];
        q_n[1]  = first_i;
        q_n[0]  = second_i;
        level_n = level_n + LW'(2);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      level_q <= '0;
    end else if (clr_i) begin
      q_q     <= '0;
      level_q <= '0;
    end else begin
      q_q     <= q_n;
      level_q <= level_n;
    end
  end

  assign level_o     = level_q;
  assign level_nxt_o = level_n;

endmodule

// File: rtl/bbuf_rx_queue.sv
module bbuf_rx_queue #(
  parameter  int DEPTH = 4,
  parameter  int BW    = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          push_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] lane0_o,
  output logic [BW-1:0] lane1_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] level_nxt_o,
  output logic          drop_o,
  output logic          rd_single_o
);

  logic [DEPTH-1:0][BW-1:0] r_q, r_a, r_n;
  logic [LW-1:0]            level_q, lvl_a, level_n;

  // read is applied first, then the push lands on the post-read level
  always_comb begin
    r_a         = r_q;
    lvl_a       = level_q;
    rd_single_o = 1'b0;
    if (rd_i) begin
      if (level_q == LW'(1)) begin
        lvl_a       = '0;
        rd_single_o = 1'b1;
      end else if (level_q >= LW'(2)) begin
        lvl_a = level_q - LW'(2);
        if (level_q > LW'(2)) begin
          for (int i = 0; i < DEPTH - 2; i++) r_a[i] = r_q[i+2];
        end
      end
    end
    r_n     = r_a;
    level_n = lvl_a;
    drop_o  = 1'b0;
    if (push_i) begin
      if (lvl_a == LW'(DEPTH)) begin
        drop_o = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (lvl_a == LW'(i)) r_n[i] = data_i;
        end
        level_n = lvl_a + LW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q     <= '0;
      level_q <= '0;
    end else if (clr_i) begin
      r_q     <= '0;
      level_q <= '0;
    end else begin
      r_q     <= r_n;
      level_q <= level_n;
    end
  end

  assign lane0_o     = r_q[0];
  assign lane1_o     = r_q[1];
  assign level_o     = level_q;
  assign level_nxt_o = level_n;

endmodule

// File: rtl/bbuf_flags.sv
module bbuf_flags
  import bbuf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        pop_i,
  input  logic        pop_empty_i,
  input  logic        wr_acc_i,
  input  logic        tx_full_i,
  input  logic        push_i,
  input  logic        drop_i,
  input  logic        rd_i,
  input  logic        rd_single_i,
  input  logic        rx_empty_i,
  output bbuf_flags_t flags_o
);

  bbuf_flags_t f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= '0;
    end else if (clr_i) begin
      f_q.single <= 1'b0;
    end else begin
      f_q.tx_udf <= pop_empty_i | (f_q.tx_udf & ~wr_acc_i);
      f_q.tx_rdy <= (f_q.tx_rdy | pop_i) & ~tx_full_i;
      f_q.rx_ovr <= drop_i | (f_q.rx_ovr & ~rd_i);
      f_q.rx_rdy <= (f_q.rx_rdy | push_i) & ~(rd_i & rx_empty_i);
      f_q.single <= f_q.single | rd_single_i;
    end
  end

  assign flags_o = f_q;

endmodule

// File: rtl/bbuf_top.sv
module bbuf_top
  import bbuf_pkg::*;
#(
  parameter  int DEPTH  = 4,
  parameter  int BYTE_W = 8,
  localparam int HW     = 2 * BYTE_W,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              swap_i,
  input  logic              host_wr_i,
  input  logic              host_wr_byte_i,
  input  logic [HW-1:0]     host_wdata_i,
  input  logic              host_rd_i,
  output logic [HW-1:0]     host_rdata_o,
  input  logic              tx_pop_i,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic [LW-1:0]     tx_level_o,
  output logic [LW-1:0]     rx_level_o,
  output logic              tx_udf_o,
  output logic              tx_rdy_o,
  output logic              rx_ovr_o,
  output logic              rx_rdy_o,
  output logic              single_o
);

  logic [BYTE_W-1:0] first_b, second_b, lane0, lane1;
  logic [LW-1:0]     tx_lvl_nxt, rx_lvl_nxt;
  logic              wr_acc, pop_empty, drop, rd_single;
  bbuf_flags_t       flags;

  bbuf_order #(.BW(BYTE_W)) u_order (
    .swap_i   (swap_i),
    .wword_i  (host_wdata_i),
    .first_o  (first_b),
    .second_o (second_b),
    .lane0_i  (lane0),
    .lane1_i  (lane1),
    .rword_o  (host_rdata_o)
  );

  bbuf_tx_queue #(.DEPTH(DEPTH), .BW(BYTE_W)) u_txq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .wr_i        (host_wr_i),
    .wr_byte_i   (host_wr_byte_i),
    .first_i     (first_b),
    .second_i    (second_b),
    .byte_i      (host_wdata_i[BYTE_W-1:0]),
    .pop_i       (tx_pop_i),
    .data_o      (tx_data_o),
    .level_o     (tx_level_o),
    .level_nxt_o (tx_lvl_nxt),
    .wr_acc_o    (wr_acc),
    .pop_empty_o (pop_empty)
  );

  bbuf_rx_queue #(.DEPTH(DEPTH), .BW(BYTE_W)) u_rxq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .rd_i        (host_rd_i),
    .push_i      (rx_push_i),
    .data_i      (rx_data_i),
    .lane0_o     (lane0),
    .lane1_o     (lane1),
    .level_o     (rx_level_o),
    .level_nxt_o (rx_lvl_nxt),
    .drop_o      (drop),
    .rd_single_o (rd_single)
  );

  bbuf_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .pop_i       (tx_pop_i),
    .pop_empty_i (pop_empty),
    .wr_acc_i    (wr_acc),
    .tx_full_i   (wr_acc & (tx_lvl_nxt > LW'(DEPTH - 2))),
    .push_i      (rx_push_i),
    .drop_i      (drop),
    .rd_i        (host_rd_i),
    .rd_single_i (rd_single),
    .rx_empty_i  (rx_lvl_nxt == '0),
    .flags_o     (flags)
  );

  assign tx_udf_o = flags.tx_udf;
  assign tx_rdy_o = flags.tx_rdy;
  assign rx_ovr_o = flags.rx_ovr;
  assign rx_rdy_o = flags.rx_rdy;
  assign single_o = flags.single;

endmodule

// File: rtl/bbuf_checker.sv
module bbuf_checker #(
  parameter  int DEPTH  = 4,
  parameter  int BYTE_W = 8,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic              tx_pop_i,
  input logic              rx_push_i,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic [LW-1:0]     tx_level_o,
  input logic [LW-1:0]     rx_level_o,
  input logic              tx_udf_o,
  input logic              tx_rdy_o,
  input logic              rx_ovr_o,
  input logic              rx_rdy_o,
  input logic              single_o
);

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LW'(DEPTH)) && (rx_level_o <= LW'(DEPTH))); // R7

  AST_WRITE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !tx_pop_i && !start_i && (tx_level_o > LW'(DEPTH - 2))
    |=> $stable(tx_level_o)); // R4

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o == '0) |-> (tx_data_o == '0)); // R5

  AST_UNDERFLOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i && !start_i && (tx_level_o == '0) |=> tx_udf_o); // R5

  AST_POP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i && !host_wr_i && !start_i |=> tx_rdy_o); // R5

  AST_PUSH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && !start_i |=> rx_rdy_o); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && !host_rd_i && !start_i && (rx_level_o == LW'(DEPTH))
    |=> rx_ovr_o && (rx_level_o == LW'(DEPTH))); // R7

  AST_READ_DROPS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !rx_push_i && !start_i && (rx_level_o >= LW'(2))
    |=> rx_level_o == $past(rx_level_o) - LW'(2)); // R9

  AST_SINGLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !rx_push_i && !start_i && (rx_level_o == LW'(1))
    |=> single_o && (rx_level_o == '0)); // R9

  AST_READ_CLEARS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !rx_push_i && !start_i |=> !rx_ovr_o); // R10

  AST_START_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tx_level_o == '0) && (rx_level_o == '0) && !single_o); // R11

endmodule

bind bbuf_top bbuf_checker #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_bbuf_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .host_wr_i  (host_wr_i),
  .host_rd_i  (host_rd_i),
  .tx_pop_i   (tx_pop_i),
  .rx_push_i  (rx_push_i),
  .tx_data_o  (tx_data_o),
  .tx_level_o (tx_level_o),
  .rx_level_o (rx_level_o),
  .tx_udf_o   (tx_udf_o),
  .tx_rdy_o   (tx_rdy_o),
  .rx_ovr_o   (rx_ovr_o),
  .rx_rdy_o   (rx_rdy_o),
  .single_o   (single_o)
);

// File: tb/test_bbuf_top.sv
module test_bbuf_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, swap_i = 1'b0;
  logic        host_wr_i = 1'b0, host_wr_byte_i = 1'b0, host_rd_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic [7:0]  tx_data_o, rx_data_i = '0;
  logic [2:0]  tx_level_o, rx_level_o;
  logic        tx_udf_o, tx_rdy_o, rx_ovr_o, rx_rdy_o, single_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0]  tx_m[$], rx_m[$], exp_pop[$];
  logic [15:0] exp_rd[$], exp_mask[$];
  string       pop_tag[$], rd_tag[$];

  always #(CLK_P/2) clk = ~clk;

  bbuf_top i_bbuf_top (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .swap_i(swap_i),
    .host_wr_i(host_wr_i), .host_wr_byte_i(host_wr_byte_i), .host_wdata_i(host_wdata_i),
    .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
    .tx_udf_o(tx_udf_o), .tx_rdy_o(tx_rdy_o), .rx_ovr_o(rx_ovr_o),
    .rx_rdy_o(rx_rdy_o), .single_o(single_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare results mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && tx_pop_i && exp_pop.size() > 0)
      chk(pop_tag.pop_front(), tx_data_o, exp_pop.pop_front());
    if (rst_ni && host_rd_i && exp_rd.size() > 0) begin
      automatic logic [15:0] m = exp_mask.pop_front();
      chk(rd_tag.pop_front(), host_rdata_o & m, exp_rd.pop_front() & m);
    end
  end

  // driver: one cycle with any mix of strobes; scoreboard follows R12 order
  task automatic step(input bit wr, input bit wrb, input logic [15:0] wd,
                      input bit rd, input bit pop, input bit push,
                      input logic [7:0] pd, input bit st, input string tag);
    int pre_tx;
    @(posedge clk); #1;
    pre_tx = tx_m.size();
    if (st) begin
      tx_m.delete(); rx_m.delete();
    end else begin
      if (pop) begin
        exp_pop.push_back(tx_m.size() > 0 ? tx_m.pop_front() : 8'h00);
        pop_tag.push_back(tag);
      end
      if (wr && pre_tx <= 2) begin
        if (wrb) tx_m.push_back(wd[7:0]);
        else if (swap_i) begin tx_m.push_back(wd[15:8]); tx_m.push_back(wd[7:0]); end
        else begin tx_m.push_back(wd[7:0]); tx_m.push_back(wd[15:8]); end
      end
      if (rd) begin
        if (rx_m.size() == 1) begin
          exp_rd.push_back(swap_i ? {rx_m[0], 8'h00} : {8'h00, rx_m[0]});
          exp_mask.push_back(swap_i ? 16'hFF00 : 16'h00FF);
          void'(rx_m.pop_front());
        end else if (rx_m.size() >= 2) begin
          exp_rd.push_back(swap_i ? {rx_m[0], rx_m[1]} : {rx_m[1], rx_m[0]});
          exp_mask.push_back(16'hFFFF);
          void'(rx_m.pop_front()); void'(rx_m.pop_front());
        end else begin
          exp_rd.push_back(16'h0); exp_mask.push_back(16'h0);
        end
        rd_tag.push_back(tag);
      end
      if (push && rx_m.size() < 4) rx_m.push_back(pd);
    end
    start_i = st; host_wr_i = wr; host_wr_byte_i = wrb; host_wdata_i = wd;
    host_rd_i = rd; tx_pop_i = pop; rx_push_i = push; rx_data_i = pd;
    @(posedge clk); #1;
    start_i = 0; host_wr_i = 0; host_wr_byte_i = 0; host_rd_i = 0;
    tx_pop_i = 0; rx_push_i = 0;
    @(negedge clk);
  endtask

  task automatic levels(input string tag);
    chk({tag, " tx level"}, tx_level_o, tx_m.size());
    chk({tag, " rx level"}, rx_level_o, rx_m.size());
  endtask

  task automatic wr16(input logic [15:0] w, input string t);
    step(1, 0, w, 0, 0, 0, 8'h0, 0, t);
  endtask
  task automatic pop1(input string t);
    step(0, 0, 16'h0, 0, 1, 0, 8'h0, 0, t);
  endtask
  task automatic push1(input logic [7:0] b, input string t);
    step(0, 0, 16'h0, 0, 0, 1, b, 0, t);
  endtask
  task automatic rd1(input string t);
    step(0, 0, 16'h0, 1, 0, 0, 8'h0, 0, t);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    levels("R1");
    chk("R1 tx_data", tx_data_o, 0);
    chk("R1 flags", {tx_udf_o, tx_rdy_o, rx_ovr_o, rx_rdy_o, single_o}, 0);

    // R5 pop on empty
    pop1("R5 empty pop data");
    chk("R5 udf set", tx_udf_o, 1);
    chk("R5 rdy set", tx_rdy_o, 1);
    // R2/R6
    wr16(16'hA1B2, "R2");
    chk("R6 udf cleared", tx_udf_o, 0);
    chk("R6 rdy kept at 2", tx_rdy_o, 1);
    levels("R2");
    step(1, 1, 16'hEE5C, 0, 0, 0, 8'h0, 0, "R3");
    levels("R3");
    chk("R6 rdy cleared above 2", tx_rdy_o, 0);
    wr16(16'h1111, "R4");
    levels("R4 ignored write");
    chk("R4 udf unchanged", tx_udf_o, 0);
    chk("R4 rdy unchanged", tx_rdy_o, 0);
    pop1("R2 first byte low");
    chk("R5 rdy after pop", tx_rdy_o, 1);
    pop1("R2 second byte high");
    pop1("R3 lone byte");
    pop1("R5 underflow zero");
    chk("R5 udf again", tx_udf_o, 1);
    swap_i = 1'b1;
    wr16(16'hC3D4, "R2 swapped");
    pop1("R2 swapped high first");
    pop1("R2 swapped low second");
    swap_i = 1'b0;

    // R12 transmit collision
    wr16(16'h2233, "R12");
    step(1, 0, 16'h4455, 0, 1, 0, 8'h0, 0, "R12 pop beside write");
    levels("R12 write+pop");
    step(1, 0, 16'h6677, 0, 1, 0, 8'h0, 0, "R12 pop beside rejected write");
    levels("R4 R12 reject on pre-pop level");
    pop1("R12 drain a");
    pop1("R12 drain b");
    levels("R12 drained");

    // R7/R10 receive
    push1(8'h01, "R7"); push1(8'h02, "R7"); push1(8'h03, "R7"); push1(8'h04, "R7");
    chk("R7 rdy", rx_rdy_o, 1);
    push1(8'h05, "R7 overflow");
    levels("R7 full");
    chk("R7 ovr set", rx_ovr_o, 1);
    rd1("R8 lanes 0 and 1");
    chk("R10 ovr cleared", rx_ovr_o, 0);
    chk("R10 rdy kept", rx_rdy_o, 1);
    levels("R9 minus two");
    rd1("R9 shifted lanes");
    chk("R10 rdy cleared", rx_rdy_o, 0);
    levels("R10 empty");

    // R8/R9 swapped and single
    swap_i = 1'b1;
    push1(8'h5A, "R8"); push1(8'h6B, "R8");
    rd1("R8 swapped word");
    push1(8'hAA, "R9");
    rd1("R9 single byte swapped");
    chk("R9 single flag", single_o, 1);
    levels("R9 single empties");
    swap_i = 1'b0;

    // R12 receive collisions
    push1(8'h10, "R12"); push1(8'h20, "R12"); push1(8'h30, "R12");
    step(0, 0, 16'h0, 1, 0, 1, 8'h40, 0, "R12 read beside push");
    levels("R12 read+push");
    rd1("R12 push after shift");
    push1(8'hA0, "R12"); push1(8'hA1, "R12"); push1(8'hA2, "R12"); push1(8'hA3, "R12");
    step(0, 0, 16'h0, 1, 0, 1, 8'hA4, 0, "R12 full read+push");
    chk("R12 no overrun", rx_ovr_o, 0);
    levels("R12 full read+push");
    rd1("R12 remaining");

    // R11 start
    wr16(16'h9988, "R11");
    step(0, 0, 16'h0, 0, 0, 0, 8'h0, 1, "R11");
    levels("R11 cleared");
    chk("R11 single cleared", single_o, 0);
    pop1("R11 empty after start");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule